// File: doc/BRIEF.md
# Single-to-Half Float Converter

This unit narrows a 32-bit binary floating-point operand to a 16-bit half-precision value. It takes one operand per cycle, qualified by `inValid`. The result and four exception flags appear in a register one cycle later, qualified by `outValid`. While `inValid` is low, the output register keeps its last contents.

Two output encodings are offered, chosen by `altMode`:

- **IEEE half precision.** This is the default.
- **Alternative half format.** It has no infinities and no NaNs. The all-ones exponent holds ordinary normal numbers, so its range reaches just under 2^17. Inputs this format cannot represent are forced to a signed zero or a signed maximum, and the invalid flag is raised.

A default-NaN control replaces every NaN result in IEEE mode with one fixed quiet NaN. Rounding is always round-to-nearest-even.

Top module: `fp_half_narrow`

## Requirements
- R1: `outValid` is high exactly in the cycle after a cycle where `inValid` was high. When `inValid` is low, `outData` and all flags keep their previous values.
- R2: While `rstN` is low, `outValid`, `outData` and all four flags are zero.
- R3: In IEEE mode with `defaultNan` low, a NaN input (exponent all ones, fraction nonzero) gives: the input sign, exponent 0x1F, and as fraction the input fraction bits 22..13. If those ten bits are zero, the result is 0x7E00 instead.
- R4: In IEEE mode with `defaultNan` high, every NaN input gives 0x7E00, whatever its sign or payload.
- R5: A NaN input whose fraction bit 22 is clear (signalling) raises invalid in both modes. A NaN with bit 22 set raises no flag.
- R6: In alternative mode, a NaN input gives a zero with the input sign.
- R7: An infinite input gives a same-signed 0x7C00 with no flags in IEEE mode. In alternative mode it gives a same-signed 0x7FFF and raises invalid.
- R8: An input whose exponent and fraction are both zero gives a zero of the same sign with no flags, independent of the sign. An input with exponent zero and a nonzero fraction gives a signed zero with inexact and underflow.
- R9: A finite input whose unbiased exponent is -14 or more is rounded to 10 fraction bits, nearest-even. Inexact is raised exactly when a dropped bit is nonzero. A carry out of the fraction increments the exponent.
- R10: A finite input with unbiased exponent below -14 becomes a subnormal (units of 2^-24), rounded nearest-even. Exactly 2^-25 gives zero; anything above 2^-25 and below 2^-24 gives 0x0001. Underflow is raised when such a result is inexact, and only then.
- R11: In IEEE mode, a finite result whose rounded magnitude reaches 2^16 gives a same-signed 0x7C00 with overflow and inexact.
- R12: In alternative mode, a finite result whose rounded magnitude exceeds 0x7FFF's value gives a same-signed 0x7FFF with invalid and inexact. Overflow is never raised in alternative mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand qualifier |
| inData | input | 32 | Single-precision operand |
| altMode | input | 1 | 1 selects the alternative half format, 0 selects IEEE |
| defaultNan | input | 1 | 1 forces every IEEE-mode NaN result to 0x7E00 |
| outValid | output | 1 | Result qualifier, one cycle after inValid |
| outData | output | 16 | Half-precision result |
| flagInvalid | output | 1 | Invalid-operation flag |
| flagOverflow | output | 1 | Overflow flag (IEEE mode only) |
| flagUnderflow | output | 1 | Tiny-and-inexact flag |
| flagInexact | output | 1 | Inexact flag |

## Verification

**Finite operands.** A sweep covers unbiased exponents from -30 to +17, plus a few far outside that range. Each exponent is combined with fraction patterns chosen for specific effects:

- exact values;
- exact ties with odd and with even kept bits;
- values just above a tie;
- all-ones fractions that carry into the exponent;
- pseudo-random fractions.

Each pattern is applied with both signs and in both modes. Together these separate correct tie-breaking from plain round-half-up, and the normal path from the subnormal path. They also expose the IEEE overflow threshold and the alternative-format saturation threshold, including where rounding alone crosses them.

**Directed cases.** These cover the subnormal/zero boundary at 2^-25, NaN payloads that truncate to zero, signalling versus quiet NaNs, default-NaN mode, infinities, signed zeros and subnormal inputs. They tell apart behaviours that a sweep of finite values never reaches.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

  // Default field widths of the source and destination formats
  localparam int SRC_EXP_W  = 8;
  localparam int SRC_FRAC_W = 23;
  localparam int DST_EXP_W  = 5;
  localparam int DST_FRAC_W = 10;

  // Strobes from the classifier to the datapath
  typedef struct packed {
    logic load;        // capture a new result this cycle
    logic selArith;    // finite nonzero operand: shift, round, pack
    logic selNanPay;   // NaN carrying its narrowed payload
    logic selDefNan;   // canonical quiet NaN
    logic selZero;     // signed zero
    logic selInf;      // signed infinity
    logic selMax;      // signed largest magnitude
    logic setInvalid;
    logic setInexact;
    logic setUnder;
  } hcvtStrobe_t;

endpackage

// File: rtl/hcvt_round.sv
// Right shift by a variable amount with round-to-nearest-even on the dropped bits.
module hcvt_round #(
  parameter int SIG_W    = 24,
  parameter int DROP_MAX = 25,
  localparam int DW      = $clog2(DROP_MAX + 1),
  localparam int PAD     = DROP_MAX + 1,
  localparam int EXT_W   = SIG_W + PAD
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [DW-1:0]    dropAmt,   // never above DROP_MAX
  output logic [SIG_W:0]   rounded,
  output logic             inexact
);

  logic [EXT_W-1:0] stage [DW+1];
  logic [SIG_W-1:0] kept;
  logic             roundBit;
  logic             sticky;
  logic             bump;

  assign stage[0] = {sig, {PAD{1'b0}}};

  // Logarithmic shifter, one stage per bit of the shift amount
  for (genvar g = 0; g < DW; g++) begin : g_shift
    assign stage[g+1] = dropAmt[g] ? (stage[g] >> (1 << g)) : stage[g];
  end

  assign kept     = stage[DW][EXT_W-1 -: SIG_W];
  assign roundBit = stage[DW][PAD-1];
  assign sticky   = |stage[DW][PAD-2:0];
  assign bump     = roundBit & (sticky | kept[0]);
  assign rounded  = {1'b0, kept} + (SIG_W+1)'(bump);
  assign inexact  = roundBit | sticky;

endmodule

// File: rtl/hcvt_ctrl.sv
// Operand classifier: decides which result source and which fixed flags apply.
module hcvt_ctrl
  import hcvt_pkg::*;
#(
  parameter int EXP_W   = SRC_EXP_W,
  parameter int FRAC_W  = SRC_FRAC_W,
  parameter int OFRAC_W = DST_FRAC_W
) (
  input  logic              inValid,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [FRAC_W-1:0] inFrac,
  input  logic              altMode,
  input  logic              defaultNan,
  output hcvtStrobe_t       strobe
);

  logic expOnes, expZero, fracZero, quietBit, payNonZero;
  logic isNan, isInf, isZero, isSubIn, isFinite;

  always_comb begin
    expOnes    = &inExp;
    expZero    = ~|inExp;
    fracZero   = ~|inFrac;
    quietBit   = inFrac[FRAC_W-1];
    payNonZero = |inFrac[FRAC_W-1 -: OFRAC_W];

    isNan    = expOnes & ~fracZero;
    isInf    = expOnes & fracZero;
    isZero   = expZero & fracZero;   // sign plays no part
    isSubIn  = expZero & ~fracZero;
    isFinite = ~expOnes & ~expZero;

    strobe            = '0;
    strobe.load       = inValid;
    strobe.selArith   = isFinite;
    strobe.selNanPay  = isNan & ~altMode & ~defaultNan & payNonZero;
    strobe.selDefNan  = isNan & ~altMode & (defaultNan | ~payNonZero);
    strobe.selZero    = isZero | isSubIn | (isNan & altMode);
    strobe.selInf     = isInf & ~altMode;
    strobe.selMax     = isInf & altMode;
    strobe.setInvalid = (isNan & ~quietBit) | (isInf & altMode);
    strobe.setInexact = isSubIn;
    strobe.setUnder   = isSubIn;
  end

endmodule

// File: rtl/hcvt_dp.sv
// Datapath: exponent rebias, denormalising shift, rounding, range handling, output register.
module hcvt_dp
  import hcvt_pkg::*;
#(
  parameter int EXP_W   = SRC_EXP_W,
  parameter int FRAC_W  = SRC_FRAC_W,
  parameter int OEXP_W  = DST_EXP_W,
  parameter int OFRAC_W = DST_FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  hcvtStrobe_t       strobe,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [FRAC_W-1:0] inFrac,
  input  logic              altMode,
  output logic              outValid,
  output logic [OEXP_W+OFRAC_W:0] outData,
  output logic              flagInvalid,
  output logic              flagOverflow,
  output logic              flagUnderflow,
  output logic              flagInexact
);

  localparam int SIG_W     = FRAC_W + 1;
  localparam int DROP_NORM = FRAC_W - OFRAC_W;
  localparam int DROP_MAX  = SIG_W + 1;
  localparam int DW        = $clog2(DROP_MAX + 1);
  localparam int TINY_SPAN = DROP_MAX - DROP_NORM;
  localparam int EW        = EXP_W + 2;
  localparam int OW        = OEXP_W + OFRAC_W;
  localparam int PW        = EXP_W + OFRAC_W + 2;
  localparam int IN_BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int OUT_BIAS  = (1 << (OEXP_W - 1)) - 1;
  localparam int OUT_EMIN  = 1 - OUT_BIAS;
  localparam logic [OW-1:0] INF_MAG = {{OEXP_W{1'b1}}, {OFRAC_W{1'b0}}};
  localparam logic [OW-1:0] MAX_MAG = {OW{1'b1}};
  localparam logic [OW:0]   DEF_NAN = {1'b0, {OEXP_W{1'b1}}, 1'b1, {(OFRAC_W-1){1'b0}}};

  logic signed [EW-1:0] unbExp, deficit, biasedOut;
  logic                 isTiny;
  logic [DW-1:0]        dropAmt;
  logic [SIG_W:0]       rounded;
  logic                 rndInexact;
  logic [PW-1:0]        magnitude;

  logic [OW:0] nextData;
  logic        nextInv, nextOvf, nextUnf, nextInx;

  // Exponent handling and shift amount
  always_comb begin
    unbExp    = $signed({2'b00, inExp}) - EW'(IN_BIAS);
    isTiny    = unbExp < EW'(OUT_EMIN);
    deficit   = EW'(OUT_EMIN) - unbExp;
    biasedOut = unbExp + EW'(OUT_BIAS);
    if (!isTiny)                        dropAmt = DW'(DROP_NORM);
    else if (deficit > EW'(TINY_SPAN))  dropAmt = DW'(DROP_MAX);
    else                                dropAmt = DW'(deficit) + DW'(DROP_NORM);
  end

  hcvt_round #(
    .SIG_W    (SIG_W),
    .DROP_MAX (DROP_MAX)
  ) u_round (
    .sig     ({1'b1, inFrac}),
    .dropAmt (dropAmt),
    .rounded (rounded),
    .inexact (rndInexact)
  );

  // A carry out of the rounded significand ripples into the exponent field
  always_comb begin
    if (isTiny)
      magnitude = PW'(rounded);
    else
      magnitude = ((PW'($unsigned(biasedOut)) - PW'(1)) << OFRAC_W) + PW'(rounded);
  end

  // Result selection
  always_comb begin
    nextData = '0;
    nextInv  = strobe.setInvalid;
    nextOvf  = 1'b0;
    nextUnf  = strobe.setUnder;
    nextInx  = strobe.setInexact;
    if (strobe.selArith) begin
      if (!altMode && magnitude >= PW'(INF_MAG)) begin
        nextData = {inSign, INF_MAG};
        nextOvf  = 1'b1;
        nextInx  = 1'b1;
      end else if (altMode && magnitude > PW'(MAX_MAG)) begin
        nextData = {inSign, MAX_MAG};
        nextInv  = 1'b1;
        nextInx  = 1'b1;
      end else begin
        nextData = {inSign, magnitude[OW-1:0]};
        nextInx  = rndInexact;
        nextUnf  = isTiny & rndInexact;
      end
    end else if (strobe.selNanPay) begin
      nextData = {inSign, {OEXP_W{1'b1}}, inFrac[FRAC_W-1 -: OFRAC_W]};
    end else if (strobe.selDefNan) begin
      nextData = DEF_NAN;
    end else if (strobe.selInf) begin
      nextData = {inSign, INF_MAG};
    end else if (strobe.selMax) begin
      nextData = {inSign, MAX_MAG};
    end else if (strobe.selZero) begin
      nextData = {inSign, {OW{1'b0}}};
    end
  end

  // Output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outData       <= '0;
      flagInvalid   <= 1'b0;
      flagOverflow  <= 1'b0;
      flagUnderflow <= 1'b0;
      flagInexact   <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outData       <= nextData;
        flagInvalid   <= nextInv;
        flagOverflow  <= nextOvf;
        flagUnderflow <= nextUnf;
        flagInexact   <= nextInx;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !outValid && $stable(outData) && $stable(flagInexact));
  // R3
  nan_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.selNanPay |=> (&outData[OW-1 -: OEXP_W]) && (|outData[OFRAC_W-1:0]));
  // R7
  ieee_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.selInf |=> outData[OW-1:0] == INF_MAG && !flagInvalid);
  // R10
  under_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagUnderflow |-> flagInexact);
  // R11
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> flagInexact && outData[OW-1:0] == INF_MAG);
  // R12
  alt_no_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && altMode |=> !flagOverflow);

endmodule

// File: rtl/fp_half_narrow.sv
module fp_half_narrow
  import hcvt_pkg::*;
#(
  parameter int EXP_W   = SRC_EXP_W,
  parameter int FRAC_W  = SRC_FRAC_W,
  parameter int OEXP_W  = DST_EXP_W,
  parameter int OFRAC_W = DST_FRAC_W,
  localparam int IN_W   = 1 + EXP_W + FRAC_W,
  localparam int OUT_W  = 1 + OEXP_W + OFRAC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  input  logic             altMode,
  input  logic             defaultNan,
  output logic             outValid,
  output logic [OUT_W-1:0] outData,
  output logic             flagInvalid,
  output logic             flagOverflow,
  output logic             flagUnderflow,
  output logic             flagInexact
);

  hcvtStrobe_t       strobe;
  logic              inSign;
  logic [EXP_W-1:0]  inExp;
  logic [FRAC_W-1:0] inFrac;

  assign inSign = inData[IN_W-1];
  assign inExp  = inData[IN_W-2 -: EXP_W];
  assign inFrac = inData[FRAC_W-1:0];

  hcvt_ctrl #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .OFRAC_W (OFRAC_W)
  ) u_ctrl (
    .inValid    (inValid),
    .inExp      (inExp),
    .inFrac     (inFrac),
    .altMode    (altMode),
    .defaultNan (defaultNan),
    .strobe     (strobe)
  );

  hcvt_dp #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .OEXP_W  (OEXP_W),
    .OFRAC_W (OFRAC_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .inSign        (inSign),
    .inExp         (inExp),
    .inFrac        (inFrac),
    .altMode       (altMode),
    .outValid      (outValid),
    .outData       (outData),
    .flagInvalid   (flagInvalid),
    .flagOverflow  (flagOverflow),
    .flagUnderflow (flagUnderflow),
    .flagInexact   (flagInexact)
  );

endmodule

// File: tb/fp_half_narrow_bench.sv
module fp_half_narrow_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        altMode = 1'b0;
  logic        defaultNan = 1'b0;
  logic        outValid;
  logic [15:0] outData;
  logic        flagInvalid, flagOverflow, flagUnderflow, flagInexact;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_half_narrow u_fp_half_narrow (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .altMode(altMode), .defaultNan(defaultNan), .outValid(outValid),
    .outData(outData), .flagInvalid(flagInvalid), .flagOverflow(flagOverflow),
    .flagUnderflow(flagUnderflow), .flagInexact(flagInexact)
  );

  function automatic real pow2(input int n);
    real r = 1.0;
    if (n >= 0) repeat (n) r = r * 2.0;
    else        repeat (-n) r = r / 2.0;
    return r;
  endfunction

  // Reference model; flags packed as {invalid, overflow, underflow, inexact}
  task automatic model(input logic [31:0] a, input logic alt, input logic dn,
                       output logic [15:0] r, output logic [3:0] f);
    logic s;
    logic [7:0] ex;
    logic [22:0] fr;
    int k, m, mag;
    real sc, flr, diff;
    bit tiny, inx;
    s = a[31]; ex = a[30:23]; fr = a[22:0]; f = 4'b0000;
    if (ex == 8'hFF) begin
      if (fr != 0) begin
        f[3] = ~fr[22];
        if (alt)                  r = {s, 15'h0000};
        else if (dn)              r = 16'h7E00;
        else if (fr[22:13] != 0)  r = {s, 5'h1F, fr[22:13]};
        else                      r = 16'h7E00;
      end else if (alt) begin
        r = {s, 15'h7FFF}; f = 4'b1000;
      end else begin
        r = {s, 15'h7C00};
      end
    end else if (ex == 8'h00) begin
      r = {s, 15'h0000};
      if (fr != 0) f = 4'b0011;
    end else begin
      k    = int'(ex) - 127;
      tiny = (k < -14);
      sc   = (1.0 + real'(fr) / pow2(23)) * (tiny ? pow2(k + 24) : pow2(10));
      flr  = $floor(sc);
      diff = sc - flr;
      m    = $rtoi(flr);
      if (diff > 0.5 || (diff == 0.5 && (m % 2) == 1)) m = m + 1;
      inx  = (diff != 0.0);
      mag  = tiny ? m : ((k + 14) * 1024 + m);
      if (!alt && mag >= 32'h7C00) begin
        r = {s, 15'h7C00}; f = 4'b0101;
      end else if (alt && mag > 32'h7FFF) begin
        r = {s, 15'h7FFF}; f = 4'b1001;
      end else begin
        r = {s, mag[14:0]}; f = {2'b00, tiny && inx, inx};
      end
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic alt, input logic dn);
    @(negedge clk);
    inData = a; altMode = alt; defaultNan = dn; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic compare(input string tag, input logic [31:0] a,
                         input logic [15:0] er, input logic [3:0] ef);
    logic [3:0] af;
    af = {flagInvalid, flagOverflow, flagUnderflow, flagInexact};
    checks++;
    if (outValid !== 1'b1 || outData !== er || af !== ef) begin
      failures++;
      $display("FAIL %s in=%08h alt=%0b: got v=%0b data=%04h flags=%04b, expected v=1 data=%04h flags=%04b",
               tag, a, altMode, outValid, outData, af, er, ef);
    end
  endtask

  task automatic directed(input string tag, input logic [31:0] a, input logic alt,
                          input logic dn, input logic [15:0] er, input logic [3:0] ef);
    apply(a, alt, dn);
    compare(tag, a, er, ef);
  endtask

  task automatic swept(input logic [31:0] a, input logic alt);
    logic [15:0] er;
    logic [3:0]  ef;
    int k;
    string tag;
    model(a, alt, 1'b0, er, ef);
    k = int'(a[30:23]) - 127;
    if (k < -14)                   tag = "R10 subnormal sweep";
    else if (!alt && ef[2])        tag = "R11 overflow sweep";
    else if (alt && ef[3])         tag = "R12 saturation sweep";
    else                           tag = "R9 normal sweep";
    apply(a, alt, 1'b0);
    compare(tag, a, er, ef);
  endtask

  logic [22:0] fracSet [12] = '{23'h000000, 23'h000001, 23'h001000, 23'h001001,
                                23'h002000, 23'h003000, 23'h7FFFFF, 23'h400000,
                                23'h001FFF, 23'h7FE000, 23'h7FF000, 23'h7FEFFF};

  initial begin
    logic [15:0] held;
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    repeat (3) @(negedge clk);

    // R2: reset state
    checks++;
    if (outValid !== 1'b0 || outData !== 16'h0000 ||
        {flagInvalid, flagOverflow, flagUnderflow, flagInexact} !== 4'b0000) begin
      failures++;
      $display("FAIL R2 reset: got v=%0b data=%04h, expected v=0 data=0000 flags=0000", outValid, outData);
    end
    rstN = 1'b1;

    // R3, R5 NaN payload narrowing in IEEE mode
    directed("R3 quiet payload",        32'hFFE02000, 0, 0, 16'hFF01, 4'b0000);
    directed("R3 payload truncates",    32'h7F800001, 0, 0, 16'h7E00, 4'b1000);
    directed("R5 signalling payload",   32'h7FA00000, 0, 0, 16'h7D00, 4'b1000);
    // R4 default NaN
    directed("R4 default quiet",        32'hFFC12345, 0, 1, 16'h7E00, 4'b0000);
    directed("R4 default signalling",   32'hFF812345, 0, 1, 16'h7E00, 4'b1000);
    // R6 alternative-mode NaN
    directed("R6 alt quiet NaN",        32'hFFC00000, 1, 0, 16'h8000, 4'b0000);
    directed("R6 alt signalling NaN",   32'h7F800001, 1, 1, 16'h0000, 4'b1000);
    // R7 infinities
    directed("R7 ieee -inf",            32'hFF800000, 0, 0, 16'hFC00, 4'b0000);
    directed("R7 alt +inf",             32'h7F800000, 1, 0, 16'h7FFF, 4'b1000);
    directed("R7 alt -inf",             32'hFF800000, 1, 0, 16'hFFFF, 4'b1000);
    // R8 zeros and subnormal inputs
    directed("R8 negative zero",        32'h80000000, 0, 0, 16'h8000, 4'b0000);
    directed("R8 positive zero alt",    32'h00000000, 1, 0, 16'h0000, 4'b0000);
    directed("R8 subnormal input",      32'h80000001, 0, 0, 16'h8000, 4'b0011);
    // R10 zero/subnormal boundary
    directed("R10 exactly 2^-25",       32'h33000000, 0, 0, 16'h0000, 4'b0011);
    directed("R10 just above 2^-25",    32'h33000001, 0, 0, 16'h0001, 4'b0011);
    directed("R10 1.5*2^-25",           32'h33400000, 0, 0, 16'h0001, 4'b0011);
    directed("R10 exactly 2^-24",       32'h33800000, 0, 0, 16'h0001, 4'b0000);
    directed("R10 tie to even",         32'h33C00000, 0, 0, 16'h0002, 4'b0011);
    directed("R10 round into normal",   32'h387FF000, 0, 0, 16'h0400, 4'b0011);
    // R9 normal range
    directed("R9 one",                  32'h3F800000, 0, 0, 16'h3C00, 4'b0000);
    directed("R9 min normal",           32'h38800000, 0, 0, 16'h0400, 4'b0000);
    directed("R9 max finite",           32'h477FE000, 0, 0, 16'h7BFF, 4'b0000);
    // R11 IEEE overflow by rounding
    directed("R11 round to inf",        32'h477FF000, 0, 0, 16'h7C00, 4'b0101);
    directed("R11 large negative",      32'hC8000000, 0, 0, 16'hFC00, 4'b0101);
    // R12 alternative-format range
    directed("R12 alt uses top exp",    32'h477FF000, 1, 0, 16'h7C00, 4'b0001);
    directed("R12 alt max exact",       32'h47FFE000, 1, 0, 16'h7FFF, 4'b0000);
    directed("R12 alt beyond range",    32'h48000000, 1, 0, 16'h7FFF, 4'b1001);
    directed("R12 alt round past max",  32'hC7FFF000, 1, 0, 16'hFFFF, 4'b1001);

    // R1: outputs hold while inValid is low
    held = outData;
    @(negedge clk);
    inData = 32'h3F800000; altMode = 1'b0;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== held || flagInvalid !== 1'b1) begin
      failures++;
      $display("FAIL R1 idle hold: got v=%0b data=%04h inv=%0b, expected v=0 data=%04h inv=1",
               outValid, outData, flagInvalid, held);
    end

    // Finite-value sweep: exponents -30..+17 plus a few far out, both signs and modes
    for (int alt = 0; alt < 2; alt++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = -30; k <= 17; k++) begin
          for (int j = 0; j < 16; j++) begin
            logic [22:0] fr;
            if (j < 12) fr = fracSet[j];
            else begin
              lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
              fr = lfsr[22:0];
            end
            swept({s[0], 8'(k + 127), fr}, alt[0]);
          end
        end
        swept({s[0], 8'd1,   23'h123456}, alt[0]);
        swept({s[0], 8'd254, 23'h654321}, alt[0]);
        swept({s[0], 8'd60,  23'h7FFFFF}, alt[0]);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got no completion, expected completion within 200000 cycles");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule